// File: doc/BRIEF.md
# I2C Serial EEPROM Target Model

This block is a synthesizable I2C target that acts as a 256-byte serial EEPROM. It is meant to sit on the same bus as an I2C master under test and answer it the way a small EEPROM does. That lets the master's byte sequencing, acknowledge handling and read paths be exercised against a known responder.

Both bus lines are sampled with the system clock through synchronizer chains. START and STOP conditions are found from the synchronized levels. The target drives SDA low only to acknowledge a byte or to send a zero data bit; the rest of the time it leaves the line to the pull-up. One internal byte pointer survives from one transaction to the next, so reads that carry no word address continue from where the last access stopped.

Writes take effect at once. There is no programming delay, no clock stretching and no 10-bit addressing.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target does not drive SDA, the byte pointer is 0 and every storage byte reads 0x00.
- R2: A START (SDA falling while SCL is high) seen at any point, even in the middle of a byte, restarts reception of a device address byte. A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R3: The device address byte is sent MSB first. Bits 7..4 must equal the parameter DEV_ID (default 4'b1010), bits 3..1 must equal the `strap` input, and bit 0 is the direction (1 = read, 0 = write). On a match the target pulls SDA low during the ninth clock. On a mismatch it gives no ACK and leaves SDA released until the next START or STOP.
- R4: In a write transfer, the first byte after the device address loads the pointer. Each later byte is stored at the pointer and acknowledged.
- R5: After each stored byte, only the low 4 bits of the pointer advance. A write of more than 16 bytes wraps to the start of the same 16-byte page and overwrites bytes written earlier in that transfer.
- R6: A read transfer that sends no word address returns data starting at the current pointer, which is one past the last byte accessed (after a write, that position is the page-wrapped one).
- R7: A write transfer carrying only a word address, followed by a repeated START and a read device address, returns data starting at that word address.
- R8: During a read, the pointer advances by one across the full 8-bit range after every byte sent (0xFF is followed by 0x00), so a sequential read crosses page boundaries.
- R9: When the master ACKs (SDA low in the ninth clock) the target sends the next byte. When the master NACKs, the target stops driving SDA until the next START or STOP.
- R10: While `wp` is 1, data bytes are acknowledged but not stored, the word address is still loaded, and the pointer still advances as for a normal write.
- R11: Apart from a START or STOP that interrupts it, the target changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as resolved on the bus |
| strap | input | 3 | Low device address bits (bits 3..1 of the address byte) |
| wp | input | 1 | Write protect; 1 blocks storage of data bytes |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Every response appears at the port a fixed number of system clocks after an SCL edge. Each bus line passes two synchronizer flops and one edge-detect flop, and the drive register updates on the detected edge. An ACK or data bit therefore shows on `sda_oe` three clocks after SCL falls, and a stored byte becomes readable at that same detected falling edge. The bench holds every SCL phase for ten clocks and samples SDA five clocks after SCL rises, well after the drive has settled. It changes SDA five clocks into each low phase, after the target has released the line. All bench stimulus is applied and sampled on the falling system clock edge.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_IGNORE
   } tgt_state_e;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned DEV_ADDR_W = 7;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_i;
                  sda_chain[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[g] <= 1'b1;
                  sda_chain[g] <= 1'b1;
               end else begin
                  scl_chain[g] <= scl_chain[g-1];
                  sda_chain[g] <= sda_chain[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_chain[STAGES-1];
   assign sda_s = sda_chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_eep_pkg::*;
#(
   parameter int unsigned AW       = 8,
   parameter int unsigned PAGE_W   = 4,
   parameter int unsigned STRAP_W  = 3,
   parameter logic [DEV_ADDR_W-STRAP_W-1:0] DEV_ID = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [STRAP_W-1:0] strap,
   input  logic               wp,
   input  logic [BYTE_W-1:0]  rdata,
   output logic               mem_we,
   output logic [AW-1:0]      mem_waddr,
   output logic [BYTE_W-1:0]  mem_wdata,
   output logic [AW-1:0]      mem_raddr,
   output logic               sda_oe,
   output logic               ignoring
);

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

   tgt_state_e          state;
   tgt_state_e          ack_next;
   logic [BYTE_W-1:0]   shreg;
   logic [CNT_W-1:0]    cnt;
   logic [AW-1:0]       ptr;
   logic                mack_ok;
   logic [DEV_ADDR_W-1:0] my_addr;
   logic                byte_in;
   logic [AW-1:0]       ptr_page_inc;

   assign my_addr      = {DEV_ID, strap};
   assign byte_in      = scl_fall && (cnt == FULL);
   assign ptr_page_inc = {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ack_next <= ST_IDLE;
         shreg    <= '0;
         cnt      <= '0;
         ptr      <= '0;
         mack_ok  <= 1'b0;
      end else if (start_det) begin
         state <= ST_DEV;
         cnt   <= '0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_DEV, ST_WADDR, ST_WDATA: begin
               if (scl_rise && cnt != FULL) begin
                  shreg <= {shreg[BYTE_W-2:0], sda_s};
                  cnt   <= cnt + 1'b1;
               end
               if (byte_in) begin
                  cnt <= '0;
                  if (state == ST_DEV) begin
                     if (shreg[BYTE_W-1:1] == my_addr) begin
                        state    <= ST_ACK;
                        ack_next <= shreg[0] ? ST_TX : ST_WADDR;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end else if (state == ST_WADDR) begin
                     ptr      <= shreg[AW-1:0];
                     state    <= ST_ACK;
                     ack_next <= ST_WDATA;
                  end else begin
                     ptr      <= ptr_page_inc;
                     state    <= ST_ACK;
                     ack_next <= ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt   <= '0;
                  state <= ack_next;
                  if (ack_next == ST_TX) shreg <= rdata;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  shreg <= {shreg[BYTE_W-2:0], 1'b1};
                  if (cnt == LAST_BIT) begin
                     cnt   <= '0;
                     state <= ST_MACK;
                     ptr   <= ptr + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) mack_ok <= ~sda_s;
               if (scl_fall) begin
                  if (mack_ok) begin
                     state <= ST_TX;
                     shreg <= rdata;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign mem_we    = (state == ST_WDATA) && byte_in && !wp && !start_det && !stop_det;
   assign mem_waddr = ptr;
   assign mem_wdata = shreg;
   assign mem_raddr = ptr;
   assign sda_oe    = (state == ST_ACK) || ((state == ST_TX) && !shreg[BYTE_W-1]);
   assign ignoring  = (state == ST_IGNORE);

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
   import i2c_eep_pkg::*;
#(
   parameter int unsigned AW          = 8,
   parameter int unsigned PAGE_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_ID      = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap,
   input  logic       wp,
   output logic       sda_oe
);

   localparam int unsigned STRAP_W = DEV_ADDR_W - $bits(DEV_ID);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (AW <= BYTE_W)     else $error("AW must fit in one word address byte");
      assert (PAGE_W < AW)      else $error("PAGE_W must be below AW");
      assert (STRAP_W == 3)     else $error("DEV_ID must leave three strap bits");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              mem_we;
   logic [AW-1:0]     mem_waddr;
   logic [BYTE_W-1:0] mem_wdata;
   logic [AW-1:0]     mem_raddr;
   logic [BYTE_W-1:0] mem_rdata;
   logic              ignoring;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_tgt_engine #(
      .AW     (AW),
      .PAGE_W (PAGE_W),
      .STRAP_W(3),
      .DEV_ID (DEV_ID)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .strap    (strap),
      .wp       (wp),
      .rdata    (mem_rdata),
      .mem_we   (mem_we),
      .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata),
      .mem_raddr(mem_raddr),
      .sda_oe   (sda_oe),
      .ignoring (ignoring)
   );

   eep_array #(.AW(AW), .DW(BYTE_W)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(mem_raddr),
      .rdata(mem_rdata)
   );

endmodule

// File: rtl/i2c_eep_checker.sv
module i2c_eep_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic scl_fall,
   input logic start_det,
   input logic stop_det,
   input logic wp,
   input logic mem_we,
   input logic ignoring,
   input logic sda_oe
);

   // R11
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !scl_s);

   // R2
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R10
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !wp);

   // R4
   store_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> scl_fall);

   // R3
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ignoring |-> !sda_oe);

endmodule

bind i2c_eeprom_target i2c_eep_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .scl_fall (scl_fall),
   .start_det(start_det),
   .stop_det (stop_det),
   .wp       (wp),
   .mem_we   (mem_we),
   .ignoring (ignoring),
   .sda_oe   (sda_oe)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;

   localparam logic [2:0] STRAP = 3'b101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       wp = 1'b0;
   logic       sda_oe;
   logic       smp;
   wire        sda_line = sda_m & ~sda_oe;

   int         n_chk = 0;
   int         n_fail = 0;
   logic [7:0] model [256];
   logic [7:0] mptr;

   always #5 clk = ~clk;

   i2c_eeprom_target u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_m),
      .sda_i (sda_line),
      .strap (STRAP),
      .wp    (wp),
      .sda_oe(sda_oe)
   );

   function automatic logic [7:0] f_page_inc(input logic [7:0] a);
      return {a[7:4], a[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] f_dev(input logic [2:0] s, input logic rd);
      return {4'b1010, s, rd};
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_bit(input logic b);
      @(negedge clk) sda_m = b;
      wt(5); scl_m = 1'b1;
      wt(5); smp = sda_line;
      wt(5); scl_m = 1'b0;
      wt(5);
   endtask

   task automatic t_start();
      @(negedge clk) sda_m = 1'b1;
      wt(5); scl_m = 1'b1;
      wt(5); sda_m = 1'b0;
      wt(5); scl_m = 1'b0;
      wt(5);
   endtask

   task automatic t_stop();
      @(negedge clk) sda_m = 1'b0;
      wt(5); scl_m = 1'b1;
      wt(5); sda_m = 1'b1;
      wt(10);
   endtask

   task automatic t_wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) t_bit(b[i]);
      t_bit(1'b1);
      ack = ~smp;
   endtask

   task automatic t_rbyte(input logic mack, output logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         t_bit(1'b1);
         d = {d[6:0], smp};
      end
      t_bit(~mack);
   endtask

   task automatic do_write(input logic [7:0] addr, input int len, input string tag);
      logic ack;
      logic [7:0] d;
      t_start();
      t_wbyte(f_dev(STRAP, 1'b0), ack);
      chk(ack, "R3 device ack", ack, 1);
      t_wbyte(addr, ack);
      chk(ack, "R4 word address ack", ack, 1);
      mptr = addr;
      for (int i = 0; i < len; i++) begin
         d = 8'($urandom);
         t_wbyte(d, ack);
         chk(ack, tag, ack, 1);
         if (!wp) model[mptr] = d;
         mptr = f_page_inc(mptr);
      end
      t_stop();
   endtask

   task automatic read_body(input int len, input string tag);
      logic [7:0] d;
      for (int i = 0; i < len; i++) begin
         t_rbyte(i != len - 1, d);
         chk(d == model[mptr], tag, d, model[mptr]);
         mptr = mptr + 8'd1;
      end
   endtask

   task automatic do_cur_read(input int len, input string tag);
      logic ack;
      t_start();
      t_wbyte(f_dev(STRAP, 1'b1), ack);
      chk(ack, "R3 read device ack", ack, 1);
      read_body(len, tag);
      t_stop();
   endtask

   task automatic do_rand_read(input logic [7:0] addr, input int len, input string tag);
      logic ack;
      t_start();
      t_wbyte(f_dev(STRAP, 1'b0), ack);
      chk(ack, "R3 device ack", ack, 1);
      t_wbyte(addr, ack);
      chk(ack, "R7 word address ack", ack, 1);
      mptr = addr;
      t_start();
      t_wbyte(f_dev(STRAP, 1'b1), ack);
      chk(ack, "R7 repeated start read ack", ack, 1);
      read_body(len, tag);
      t_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] d;
      void'($urandom(32'd4711));
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      mptr = 8'h00;
      wt(4);
      chk(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
      rst_n = 1'b1;
      wt(10);
      chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);

      // R1, R6: first current-address read starts at 0 and returns zeros
      do_cur_read(2, "R1 R6 initial read");

      // R4 byte write, R7 random read back
      do_write(8'h10, 1, "R4 byte write ack");
      do_rand_read(8'h10, 1, "R7 random read data");

      // R3 mismatching strap bits: no ACK, line left released
      t_start();
      t_wbyte(f_dev(STRAP ^ 3'b010, 1'b0), ack);
      chk(!ack, "R3 no ack for other address", ack, 0);
      t_wbyte(8'h00, ack);
      chk(!ack, "R3 ignored until stop", ack, 0);
      t_stop();
      chk(sda_oe == 1'b0, "R3 released after ignored transfer", sda_oe, 0);
      do_rand_read(8'h00, 1, "R3 storage untouched");

      // R5 page write of 20 bytes wraps within page 0x30
      do_write(8'h3C, 20, "R5 page write ack");
      do_cur_read(1, "R5 R6 current read after page wrap");
      do_rand_read(8'h30, 16, "R5 R8 page contents");

      // R2 START inside a byte restarts address reception
      t_start();
      t_bit(1'b1); t_bit(1'b0); t_bit(1'b1); t_bit(1'b1);
      t_start();
      t_wbyte(f_dev(STRAP, 1'b0), ack);
      chk(ack, "R2 ack after restart", ack, 1);
      t_wbyte(8'h55, ack);
      chk(ack, "R2 word address ack", ack, 1);
      t_wbyte(8'hC3, ack);
      chk(ack, "R2 data ack", ack, 1);
      model[8'h55] = 8'hC3;
      mptr = 8'h56;
      t_stop();
      chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
      do_rand_read(8'h55, 1, "R2 data after restart");

      // R10 write protect: acked, not stored, pointer advances
      do_write(8'h80, 4, "R4 data ack pre wp");
      wp = 1'b1;
      do_write(8'h80, 3, "R10 data ack under wp");
      wp = 1'b0;
      do_cur_read(1, "R10 pointer advanced under wp");
      do_rand_read(8'h80, 3, "R10 data not stored");

      // R8 sequential read rolls over 0xFF -> 0x00
      do_write(8'hFE, 2, "R4 write at top");
      do_rand_read(8'hFE, 4, "R8 rollover read");

      // R9 master NACK: target stops driving
      t_start();
      t_wbyte(f_dev(STRAP, 1'b1), ack);
      chk(ack, "R9 read ack", ack, 1);
      t_rbyte(1'b0, d);
      chk(d == model[mptr], "R9 single byte", d, model[mptr]);
      mptr = mptr + 8'd1;
      for (int i = 0; i < 9; i++) begin
         t_bit(1'b1);
         chk(smp == 1'b1, "R9 released after nack", smp, 1);
      end
      t_stop();

      // randomized mix
      for (int k = 0; k < 22; k++) begin
         int kind;
         kind = int'($urandom_range(0, 2));
         if (kind == 0) do_write(8'($urandom), int'($urandom_range(1, 5)), "R4 R5 random write");
         else if (kind == 1) do_rand_read(8'($urandom), int'($urandom_range(1, 4)), "R7 R8 random read");
         else do_cur_read(int'($urandom_range(1, 3)), "R6 random current read");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule